// File: doc/BRIEF.md
# Speculative Load Alias Detector

This block lets a scheduler hoist loads above earlier stores. A load that has been moved ahead is issued as a protecting load, and the block records the byte range it reads in a small associative table. A store that might alias such a load is issued as a checked store. Its byte range is compared in parallel against every live entry, and any overlap raises an alias fault so that recovery code can discard the speculative work.

The table has a fixed number of slots, filled in order. When it is full, a new protecting load replaces the oldest slot and a sticky overflow flag is raised. A clear input, driven when the speculative window commits or rolls back, empties the table and drops the flag in one cycle. The fault comes out as a one-cycle pulse together with the index of the lowest matching slot. Plain loads and stores are issued with their valid inputs low and never touch the table.

Top module: `alias_guard`

## Requirements
- R1: After reset, fault_o and overflow_o are 0, fault_idx_o is 0 and no slot is live.
- R2: A protecting load (prot_valid_i high) records the range [prot_addr_i, prot_addr_i + 2^prot_size_i) in the next slot in fill order. Slot k receives the (k+1)-th protecting load since the last clear or reset, for k = 0..DEPTH-1.
- R3: A checked store (chk_valid_i high) whose range overlaps any live slot drives fault_o high in the cycle after it is presented, for exactly that one cycle per store.
- R4: The overlap test works on byte ranges. Size code 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes. Ranges that only touch do not overlap. A range is never wrapped past the top of the address space, so a region that ends above the highest address does not cover address 0.
- R5: While prot_valid_i and chk_valid_i are low, the address and size inputs have no effect: nothing is recorded and no fault is raised.
- R6: During a fault, fault_idx_o is the lowest slot index among all matching slots. When there is no fault it is 0.
- R7: A protecting load that arrives while all DEPTH slots are live overwrites the oldest slot (the slots are reused in order 0, 1, ...) and sets overflow_o from the next cycle on. overflow_o then stays high until a clear.
- R8: clear_i empties every slot and drops overflow_o in the next cycle. It takes precedence over a protecting load or checked store in the same cycle: that load is not recorded and that store does not fault.
- R9: When a protecting load and a checked store arrive in the same cycle, the store is compared only against slots that were live before that cycle, and the load is still recorded.
- R10: Checked stores never change the table. Repeating a store that faulted faults again with the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prot_valid_i | input | 1 | Protecting load request |
| prot_addr_i | input | ADDR_W | Byte address of the protecting load |
| prot_size_i | input | 2 | log2 of the protecting load's size in bytes |
| chk_valid_i | input | 1 | Checked store request |
| chk_addr_i | input | ADDR_W | Byte address of the checked store |
| chk_size_i | input | 2 | log2 of the checked store's size in bytes |
| clear_i | input | 1 | Commit or rollback: empty the table |
| fault_o | output | 1 | Alias fault pulse |
| fault_idx_o | output | $clog2(DEPTH) | Lowest matching slot during a fault |
| overflow_o | output | 1 | Sticky flag: a live slot was overwritten |

## Verification
A wrong slot address, a wrong size or a lost valid bit shows up as a missing or extra fault_o, or a wrong fault_idx_o, on the first checked store that touches that range. The fault follows the store by exactly one cycle. A wrong fill pointer moves the index that later faults report. A wrong occupancy count shows in overflow_o on the protecting load after the eighth, or leaves a stale region that still faults after a clear. The bench keeps a behavioural model of the table and compares all three outputs after every clock. Random and directed traffic reuse a small address window so that overlaps occur often.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;
  typedef enum logic [1:0] {SZ_B1 = 2'd0, SZ_B2 = 2'd1, SZ_B4 = 2'd2, SZ_B8 = 2'd3} acc_size_e;
  localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/alias_slot.sv
module alias_slot
  import alias_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  acc_size_e         wr_size_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  acc_size_e         chk_size_i,
  output logic              valid_o,
  output logic              hit_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic              valid_q;
  logic [ADDR_W-1:0] lo_q;
  acc_size_e         size_q;
  logic [EXT_W-1:0]  a_lo, a_hi, b_lo, b_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      size_q  <= SZ_B1;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      lo_q    <= wr_addr_i;
      size_q  <= wr_size_i;
    end
  end

  // one extra bit keeps ranges from wrapping past the top address
  always_comb begin
    a_lo  = {1'b0, lo_q};
    a_hi  = a_lo + (EXT_W'(1) << size_q);
    b_lo  = {1'b0, chk_addr_i};
    b_hi  = b_lo + (EXT_W'(1) << chk_size_i);
    hit_o = valid_q && (a_lo < b_hi) && (b_lo < a_hi);
  end

  assign valid_o = valid_q;

  AST_SLOT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_i && !wr_i) |=> (valid_q && $stable(lo_q) && $stable(size_q))); // R10
endmodule

// File: rtl/alias_fill.sv
module alias_fill #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prot_i,
  input  logic             clr_i,
  output logic [DEPTH-1:0] wr_vec_o,
  output logic             ovf_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] wptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, do_wr;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign do_wr = prot_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (do_wr) begin
      wptr_q <= (wptr_q == IDX_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (full) ovf_q <= 1'b1;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    wr_vec_o = '0;
    if (do_wr) wr_vec_o[wptr_q] = 1'b1;
  end

  assign ovf_o = ovf_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && full) |=> ovf_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovf_o); // R8
endmodule

// File: rtl/alias_pick.sv
module alias_pick #(
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0]         hit_i,
  output logic                     any_o,
  output logic [$clog2(DEPTH)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  always_comb begin
    any_o = |hit_i;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/alias_guard.sv
module alias_guard
  import alias_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     prot_valid_i,
  input  logic [ADDR_W-1:0]        prot_addr_i,
  input  logic [1:0]               prot_size_i,
  input  logic                     chk_valid_i,
  input  logic [ADDR_W-1:0]        chk_addr_i,
  input  logic [1:0]               chk_size_i,
  input  logic                     clear_i,
  output logic                     fault_o,
  output logic [$clog2(DEPTH)-1:0] fault_idx_o,
  output logic                     overflow_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] wr_vec, valid_vec, hit_raw, hit_vec;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  logic             fault_q;
  logic [IDX_W-1:0] idx_q;

  alias_fill #(.DEPTH(DEPTH)) u_fill (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prot_i   (prot_valid_i),
    .clr_i    (clear_i),
    .wr_vec_o (wr_vec),
    .ovf_o    (overflow_o)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    alias_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clear_i),
      .wr_i       (wr_vec[g]),
      .wr_addr_i  (prot_addr_i),
      .wr_size_i  (acc_size_e'(prot_size_i)),
      .chk_addr_i (chk_addr_i),
      .chk_size_i (acc_size_e'(chk_size_i)),
      .valid_o    (valid_vec[g]),
      .hit_o      (hit_raw[g])
    );
  end

  // compare uses pre-edge slot contents, so a same-cycle load is not seen
  assign hit_vec = (chk_valid_i && !clear_i) ? hit_raw : '0;

  alias_pick #(.DEPTH(DEPTH)) u_pick (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      fault_q <= any_hit;
      idx_q   <= any_hit ? hit_idx : '0;
    end
  end

  assign fault_o     = fault_q;
  assign fault_idx_o = idx_q;

  AST_FAULT_NEEDS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(chk_valid_i && !clear_i)); // R3
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_vec == '0)); // R8
  AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ((($past(hit_vec) >> fault_idx_o) & DEPTH'(1)) == DEPTH'(1)
                 && ($past(hit_vec) & ((DEPTH'(1) << fault_idx_o) - DEPTH'(1))) == '0)); // R6
  AST_IDX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (fault_idx_o == '0)); // R6
endmodule

// File: tb/alias_guard_bench.sv
`timescale 1ns/1ps
module alias_guard_bench;
  localparam int AW = 32;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pv = 1'b0, cv = 1'b0, clr = 1'b0;
  logic [AW-1:0] pa = '0, ca = '0;
  logic [1:0]    ps = '0, cs = '0;
  logic          fault;
  logic [2:0]    fidx;
  logic          ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model
  longint unsigned m_lo [D];
  int              m_sz [D];
  bit              m_v  [D];
  int m_ptr = 0, m_cnt = 0;
  bit m_ovf = 0, e_fault = 0;
  int e_idx = 0;

  always #2.5 clk = ~clk;

  alias_guard #(.ADDR_W(AW), .DEPTH(D)) u_alias_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .prot_valid_i(pv), .prot_addr_i(pa), .prot_size_i(ps),
    .chk_valid_i(cv), .chk_addr_i(ca), .chk_size_i(cs),
    .clear_i(clr),
    .fault_o(fault), .fault_idx_o(fidx), .overflow_o(ovf)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit overlap(longint unsigned al, int as, longint unsigned bl, int bs);
    return (al < bl + (64'd1 << bs)) && (bl < al + (64'd1 << as));
  endfunction

  task automatic model_step();
    e_fault = 0; e_idx = 0;
    if (cv && !clr)
      for (int i = 0; i < D; i++)
        if (!e_fault && m_v[i] && overlap(m_lo[i], m_sz[i], longint'(ca), int'(cs))) begin
          e_fault = 1; e_idx = i;
        end
    if (clr) begin
      for (int i = 0; i < D; i++) m_v[i] = 0;
      m_ptr = 0; m_cnt = 0; m_ovf = 0;
    end else if (pv) begin
      if (m_cnt == D) m_ovf = 1; else m_cnt++;
      m_lo[m_ptr] = longint'(pa); m_sz[m_ptr] = int'(ps); m_v[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % D;
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cyc(input bit p, input logic [AW-1:0] a1, input logic [1:0] s1,
                     input bit c, input logic [AW-1:0] a2, input logic [1:0] s2,
                     input bit cl, input string tag);
    pv = p; pa = a1; ps = s1; cv = c; ca = a2; cs = s2; clr = cl;
    @(posedge clk);
    model_step();
    #1;
    check(fault === e_fault, {tag, " fault"}, longint'(fault), longint'(e_fault));
    check(fidx === 3'(e_idx), {tag, " idx"}, longint'(fidx), longint'(e_idx));
    check(ovf === m_ovf, {tag, " overflow"}, longint'(ovf), longint'(m_ovf));
    @(negedge clk);
    pv = 0; cv = 0; clr = 0;
  endtask

  task automatic prot(input logic [AW-1:0] a, input logic [1:0] s, input string tag);
    cyc(1, a, s, 0, '0, 0, 0, tag);
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [1:0] s, input bit ef, input int ei, input string tag);
    pv = 0; cv = 1; ca = a; cs = s; clr = 0;
    @(posedge clk);
    model_step();
    #1;
    check(fault === ef, {tag, " fault"}, longint'(fault), longint'(ef));
    check(fidx === 3'(ei), {tag, " idx"}, longint'(fidx), longint'(ei));
    check(fault === e_fault && fidx === 3'(e_idx), {tag, " model"}, longint'(fidx), longint'(e_idx));
    @(negedge clk);
    cv = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin m_v[i] = 0; m_lo[i] = 0; m_sz[i] = 0; end
    repeat (3) @(negedge clk);
    check(fault === 1'b0 && ovf === 1'b0 && fidx === 3'd0, "R1 reset outputs", longint'({fault, ovf}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    store(32'h100, 0, 0, 0, "R1 empty table");

    prot(32'h100, 2, "R2 record [100,104)");
    store(32'h104, 0, 0, 0, "R4 adjacent above");
    store(32'h103, 0, 1, 0, "R3 last byte hit");
    store(32'h0FC, 2, 0, 0, "R4 adjacent below");
    store(32'h0FE, 2, 1, 0, "R4 partial overlap");
    store(32'h0F8, 3, 0, 0, "R4 8B touching");

    cyc(0, 32'h200, 3, 0, 32'h100, 2, 0, "R5 idle inputs");
    store(32'h200, 0, 0, 0, "R5 unrecorded load");

    prot(32'h200, 3, "R2 slot1");
    prot(32'h100, 0, "R2 slot2");
    store(32'h100, 0, 1, 0, "R6 lowest of 0,2");
    store(32'h204, 1, 1, 1, "R2 slot1 hit");
    store(32'h207, 0, 1, 1, "R10 first");
    store(32'h207, 0, 1, 1, "R10 repeat");

    cyc(1, 32'h300, 0, 1, 32'h300, 0, 0, "R9 same cycle");
    check(1'b1, "R9 marker", 0, 0);
    store(32'h300, 0, 1, 3, "R9 later store sees slot3");

    cyc(1, 32'h400, 0, 1, 32'h100, 0, 1, "R8 clear wins");
    store(32'h100, 0, 0, 0, "R8 old region gone");
    store(32'h400, 0, 0, 0, "R8 load not recorded");

    for (int i = 0; i < D; i++) prot(32'h1000 + 32'(i) * 32'h10, 0, "R7 fill");
    check(ovf === 1'b0, "R7 full no overflow", longint'(ovf), 0);
    prot(32'h2000, 1, "R7 overwrite");
    check(ovf === 1'b1, "R7 overflow set", longint'(ovf), 1);
    store(32'h1000, 0, 0, 0, "R7 oldest gone");
    store(32'h2001, 0, 1, 0, "R7 new in slot0");
    store(32'h1010, 0, 1, 1, "R7 slot1 kept");
    prot(32'h3000, 0, "R7 next overwrite");
    store(32'h1010, 0, 0, 0, "R7 slot1 replaced");
    check(ovf === 1'b1, "R7 overflow sticky", longint'(ovf), 1);
    cyc(0, '0, 0, 0, '0, 0, 1, "R8 clear");
    check(ovf === 1'b0, "R8 overflow dropped", longint'(ovf), 0);

    prot(32'hFFFF_FFFC, 3, "R4 top region");
    store(32'h0000_0000, 0, 0, 0, "R4 no wrap");
    store(32'hFFFF_FFFF, 0, 1, 0, "R4 top byte");
    cyc(0, '0, 0, 0, '0, 0, 1, "R8 clear2");

    for (int n = 0; n < 400; n++) begin
      cyc($urandom_range(0, 9) < 4, 32'h100 + 32'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
          $urandom_range(0, 1) == 1, 32'h100 + 32'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
          $urandom_range(0, 39) == 0, "R3 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule